// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller. Pins are grouped into banks of 32, and each bank has its own register window. Software uses a simple synchronous register bus. Through it, software drives pins as outputs, samples them as inputs and sets up the pad resistors and drive strength. It also chooses, per pin, whether and how the pin raises an interrupt.

Every pad input first goes through a two-flop synchroniser. An event detector then compares the synchronised value with its value one cycle earlier. Three per-pin bits select the trigger mode: level versus edge, dual edge, and polarity. A detected event sets a sticky raw status bit. Software clears it by writing a one to the same bit of a separate clear register. The raw status ANDed with the per-pin mask gives the masked status. One interrupt line is asserted whenever any masked status bit in any bank is set.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: The bank is selected by address bits [ADDR_W-1:9], so banks sit 0x200 apart. Pin p lives in bank p/32 at bit p%32. Within a bank the offsets are: input 0x00, output 0x04, output enable 0x08, trigger type 0x0C, dual edge 0x10, polarity 0x14, mask 0x18, raw status 0x1C, masked status 0x20, clear 0x24, pull select 0x34, pull enable 0x38, drive planes 0x58/0x5C/0x60.
- R2: padOe equals the output-enable register. padOut carries the output-data bit only where the enable bit is 1, and is 0 elsewhere.
- R3: A read of offset 0x00 returns the pad level after two clock edges of synchronisation.
- R4: A trigger-type bit of 1 selects level sensing, with high active for polarity 1 and low active for polarity 0. While the level stays active, the status bit is set again on every cycle, including the cycle of a clear.
- R5: With trigger type 0 and dual edge 0, polarity 1 captures rising edges only and polarity 0 captures falling edges only.
- R6: With trigger type 0 and dual edge 1, both rising and falling edges set the status bit.
- R7: Offset 0x1C returns raw status whatever the mask is. Offset 0x20 returns raw status ANDed with the mask, where a mask bit of 1 enables the pin.
- R8: Writing 1 to a bit of offset 0x24 clears that status bit, and writing 0 leaves it unchanged. If an event arrives in the same cycle as the clear, the event wins. Writes to offsets 0x1C and 0x20 have no effect.
- R9: irqOut is 1 exactly when some masked status bit in some bank is 1.
- R10: pullSel follows offset 0x34 (1 = up, 0 = down). pullEn follows offset 0x38 (1 = resistor on).
- R11: Pin p's drive code is {plane 0x60 bit, plane 0x5C bit, plane 0x58 bit} and appears at driveCode[3p+2:3p]. The code is mA/2-1, covering 2 to 16 mA.
- R12: After reset every register, every status bit, padOe and irqOut is 0.
- R13: Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address (bank and offset) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| padIn | input | NUM_BANKS*32 | Pad input levels (asynchronous) |
| padOut | output | NUM_BANKS*32 | Output data, gated by the enable |
| padOe | output | NUM_BANKS*32 | Per-pin output enable |
| pullSel | output | NUM_BANKS*32 | Pull direction |
| pullEn | output | NUM_BANKS*32 | Pull resistor enable |
| driveCode | output | NUM_BANKS*96 | Three-bit drive code per pin |
| irqOut | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as an active event. Level mode produces this without exact timing: the bench holds a pin at its active level, writes its clear bit, and reads status back as still set. A second hard case is an interrupt that comes only from the second bank while every bank-0 bit is masked or clear. The bench reaches it by arming a bank-1 pin in level mode after first clearing bank 0. Dual-edge capture is checked by clearing between a rise and a fall of the same pin.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BANK_PINS = 32;
  localparam int OFS_W     = 9;

  typedef enum logic [3:0] {
    REG_NONE, REG_DIN, REG_DOUT, REG_OE, REG_TYPE, REG_DUAL, REG_POL,
    REG_MASK, REG_RAW, REG_MSTAT, REG_CLR, REG_PSEL, REG_PEN,
    REG_DRV0, REG_DRV1, REG_DRV2
  } regId_t;

  typedef struct packed {
    logic       wrEn;
    regId_t     regId;
    logic [7:0] bank;
  } busStrobe_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 10
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  localparam int BANK_W = ADDR_W - OFS_W;

  logic [BANK_W-1:0] bankIdx;
  logic [OFS_W-1:0]  offset;
  logic              bankOk;
  regId_t            decoded;

  assign bankIdx = busAddr[ADDR_W-1:OFS_W];
  assign offset  = busAddr[OFS_W-1:0];
  assign bankOk  = int'(bankIdx) < NUM_BANKS;

  always_comb begin
    case (offset)
      9'h000:  decoded = REG_DIN;
      9'h004:  decoded = REG_DOUT;
      9'h008:  decoded = REG_OE;
      9'h00C:  decoded = REG_TYPE;
      9'h010:  decoded = REG_DUAL;
      9'h014:  decoded = REG_POL;
      9'h018:  decoded = REG_MASK;
      9'h01C:  decoded = REG_RAW;
      9'h020:  decoded = REG_MSTAT;
      9'h024:  decoded = REG_CLR;
      9'h034:  decoded = REG_PSEL;
      9'h038:  decoded = REG_PEN;
      9'h058:  decoded = REG_DRV0;
      9'h05C:  decoded = REG_DRV1;
      9'h060:  decoded = REG_DRV2;
      default: decoded = REG_NONE;
    endcase
  end

  always_comb begin
    strobe.wrEn  = busSel && busWr && bankOk && (decoded != REG_NONE);
    strobe.regId = (busSel && bankOk) ? decoded : REG_NONE;
    strobe.bank  = 8'(bankIdx);
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  busStrobe_t             strobe,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  input  logic [NUM_BANKS*32-1:0] padIn,
  output logic [NUM_BANKS*32-1:0] padOut,
  output logic [NUM_BANKS*32-1:0] padOe,
  output logic [NUM_BANKS*32-1:0] pullSel,
  output logic [NUM_BANKS*32-1:0] pullEn,
  output logic [NUM_BANKS*96-1:0] driveCode,
  output logic                   irqOut
);
  localparam int NPINS = NUM_BANKS * BANK_PINS;

  logic [NPINS-1:0] syncA, syncB, prevIn;
  logic [NPINS-1:0] doutReg, oeReg, typeReg, dualReg, polReg, maskReg;
  logic [NPINS-1:0] pselReg, penReg, drv0Reg, drv1Reg, drv2Reg;
  logic [NPINS-1:0] rawStat;
  logic [NPINS-1:0] riseEvt, fallEvt, levelHit, edgeHit, pinEvt;

  // input synchroniser and one-cycle history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      prevIn <= '0;
    end else begin
      syncA  <= padIn;
      syncB  <= syncA;
      prevIn <= syncB;
    end
  end

  // trigger selection
  always_comb begin
    riseEvt  = syncB & ~prevIn;
    fallEvt  = ~syncB & prevIn;
    levelHit = (polReg & syncB) | (~polReg & ~syncB);
    edgeHit  = (dualReg & (riseEvt | fallEvt)) |
               (~dualReg & ((polReg & riseEvt) | (~polReg & fallEvt)));
    pinEvt   = (typeReg & levelHit) | (~typeReg & edgeHit);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_PINS;
    logic        wrHit;
    logic [31:0] clrBits;

    assign wrHit   = strobe.wrEn && (strobe.bank == 8'(b));
    assign clrBits = (wrHit && strobe.regId == REG_CLR) ? busWdata : 32'h0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        doutReg[LO+:32] <= '0;
        oeReg[LO+:32]   <= '0;
        typeReg[LO+:32] <= '0;
        dualReg[LO+:32] <= '0;
        polReg[LO+:32]  <= '0;
        maskReg[LO+:32] <= '0;
        pselReg[LO+:32] <= '0;
        penReg[LO+:32]  <= '0;
        drv0Reg[LO+:32] <= '0;
        drv1Reg[LO+:32] <= '0;
        drv2Reg[LO+:32] <= '0;
      end else if (wrHit) begin
        case (strobe.regId)
          REG_DOUT: doutReg[LO+:32] <= busWdata;
          REG_OE:   oeReg[LO+:32]   <= busWdata;
          REG_TYPE: typeReg[LO+:32] <= busWdata;
          REG_DUAL: dualReg[LO+:32] <= busWdata;
          REG_POL:  polReg[LO+:32]  <= busWdata;
          REG_MASK: maskReg[LO+:32] <= busWdata;
          REG_PSEL: pselReg[LO+:32] <= busWdata;
          REG_PEN:  penReg[LO+:32]  <= busWdata;
          REG_DRV0: drv0Reg[LO+:32] <= busWdata;
          REG_DRV1: drv1Reg[LO+:32] <= busWdata;
          REG_DRV2: drv2Reg[LO+:32] <= busWdata;
          default: ;
        endcase
      end
    end

    // status: new events take priority over a simultaneous clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rawStat[LO+:32] <= '0;
      else       rawStat[LO+:32] <= (rawStat[LO+:32] & ~clrBits) | pinEvt[LO+:32];
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_drv
    assign driveCode[3*p+:3] = {drv2Reg[p], drv1Reg[p], drv0Reg[p]};
  end

  always_comb begin
    busRdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobe.bank == 8'(b)) begin
        case (strobe.regId)
          REG_DIN:   busRdata = syncB[b*32+:32];
          REG_DOUT:  busRdata = doutReg[b*32+:32];
          REG_OE:    busRdata = oeReg[b*32+:32];
          REG_TYPE:  busRdata = typeReg[b*32+:32];
          REG_DUAL:  busRdata = dualReg[b*32+:32];
          REG_POL:   busRdata = polReg[b*32+:32];
          REG_MASK:  busRdata = maskReg[b*32+:32];
          REG_RAW:   busRdata = rawStat[b*32+:32];
          REG_MSTAT: busRdata = rawStat[b*32+:32] & maskReg[b*32+:32];
          REG_PSEL:  busRdata = pselReg[b*32+:32];
          REG_PEN:   busRdata = penReg[b*32+:32];
          REG_DRV0:  busRdata = drv0Reg[b*32+:32];
          REG_DRV1:  busRdata = drv1Reg[b*32+:32];
          REG_DRV2:  busRdata = drv2Reg[b*32+:32];
          default:   busRdata = '0;
        endcase
      end
    end
  end

  assign padOut  = doutReg & oeReg;
  assign padOe   = oeReg;
  assign pullSel = pselReg;
  assign pullEn  = penReg;
  assign irqOut  = |(rawStat & maskReg);

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 9 + ((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busSel,
  input  logic                    busWr,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [31:0]             busWdata,
  output logic [31:0]             busRdata,
  input  logic [NUM_BANKS*32-1:0] padIn,
  output logic [NUM_BANKS*32-1:0] padOut,
  output logic [NUM_BANKS*32-1:0] padOe,
  output logic [NUM_BANKS*32-1:0] pullSel,
  output logic [NUM_BANKS*32-1:0] pullEn,
  output logic [NUM_BANKS*96-1:0] driveCode,
  output logic                    irqOut
);
  localparam int NPINS = NUM_BANKS * BANK_PINS;

  busStrobe_t strobe;

  gpio_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  gpio_datapath #(.NUM_BANKS(NUM_BANKS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .pullSel  (pullSel),
    .pullEn   (pullEn),
    .driveCode(driveCode),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/gpio_banked_checker.sv
module gpio_banked_checker #(
  parameter int NPINS = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWr,
  input logic [NPINS-1:0] padOe,
  input logic [NPINS-1:0] pullEn,
  input logic             irqOut,
  input logic [NPINS-1:0] rawStat,
  input logic [NPINS-1:0] maskReg
);

  assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busSel && busWr) |-> $stable(padOe));

  assert_pull_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busSel && busWr) |-> $stable(pullEn));

  assert_w1c_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busSel && busWr) |-> (($past(rawStat) & ~rawStat) == '0));

  assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|maskReg));

  assert_irq_drop_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(busSel && busWr));

endmodule

bind gpio_banked_ctrl gpio_banked_checker #(.NPINS(NPINS)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busSel (busSel),
  .busWr  (busWr),
  .padOe  (padOe),
  .pullEn (pullEn),
  .irqOut (irqOut),
  .rawStat(u_dp.rawStat),
  .maskReg(u_dp.maskReg)
);

// File: tb/sim_gpio_banked_ctrl.sv
module sim_gpio_banked_ctrl;
  localparam int NB = 2;
  localparam int AW = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            busSel = 1'b0;
  logic            busWr = 1'b0;
  logic [AW-1:0]   busAddr = '0;
  logic [31:0]     busWdata = '0;
  logic [31:0]     busRdata;
  logic [NB*32-1:0] padIn = '0;
  logic [NB*32-1:0] padOut, padOe, pullSel, pullEn;
  logic [NB*96-1:0] driveCode;
  logic            irqOut;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  gpio_banked_ctrl #(.NUM_BANKS(NB)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .pullSel(pullSel),
    .pullEn(pullEn), .driveCode(driveCode), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [9:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expRd;
  } vec_t;

  // write then read back: R1 banking, R7 mask, R10 pull, R11 planes, R8 ro status, R13 holes
  localparam vec_t VECS [9] = '{
    '{10'h004, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    '{10'h204, 32'h1234_5678, 32'h1234_5678},
    '{10'h018, 32'hFFFF_0000, 32'hFFFF_0000},
    '{10'h034, 32'h0000_00F0, 32'h0000_00F0},
    '{10'h038, 32'h0000_FF00, 32'h0000_FF00},
    '{10'h05C, 32'h8000_0001, 32'h8000_0001},
    '{10'h01C, 32'hFFFF_FFFF, 32'h0000_0000},
    '{10'h228, 32'hDEAD_BEEF, 32'h0000_0000},
    '{10'h020, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    doReset();

    foreach (VECS[i]) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rdReg(VECS[i].addr, rd);
      chk($sformatf("R1/R13 vector %0d", i), 64'(rd), 64'(VECS[i].expRd));
    end
    chk("R2 output gated while disabled", 64'(padOut), 64'h0);
    chk("R10 pullSel port", 64'(pullSel), 64'h0000_0000_0000_00F0);
    chk("R11 drive code pin0", 64'(driveCode[2:0]), 64'h2);

    doReset();
    // R12 reset state
    chk("R12 irqOut after reset", 64'(irqOut), 64'h0);
    chk("R12 padOe after reset", 64'(padOe), 64'h0);
    rdReg(10'h004, rd);
    chk("R12 output data after reset", 64'(rd), 64'h0);
    rdReg(10'h01C, rd);
    chk("R12 raw status after reset", 64'(rd), 64'h0);

    // R2 output gating
    wr(10'h004, 32'h0000_00FF);
    wr(10'h008, 32'h0000_000F);
    chk("R2 padOut gated", 64'(padOut), 64'h0000_0000_0000_000F);
    chk("R2 padOe", 64'(padOe), 64'h0000_0000_0000_000F);

    // R3 synchronised input, bank 1 bit 8
    padIn[40] = 1'b1;
    tick(2);
    rdReg(10'h200, rd);
    chk("R3 input read bank1", 64'(rd), 64'h100);

    // R5 rising edge on pin 3
    wr(10'h014, 32'h0000_0008);
    wr(10'h018, 32'h0000_0008);
    padIn[3] = 1'b1;
    tick(3);
    rdReg(10'h01C, rd);
    chk("R5 rising captured", 64'(rd), 64'h8);
    chk("R9 irq from pin3", 64'(irqOut), 64'h1);
    wr(10'h024, 32'h0);
    rdReg(10'h01C, rd);
    chk("R8 write zero keeps status", 64'(rd), 64'h8);
    wr(10'h024, 32'h8);
    rdReg(10'h01C, rd);
    chk("R8 write one clears", 64'(rd), 64'h0);
    chk("R9 irq drops after clear", 64'(irqOut), 64'h0);
    padIn[3] = 1'b0;
    tick(4);
    rdReg(10'h01C, rd);
    chk("R5 falling ignored in rising mode", 64'(rd), 64'h0);

    // R6 dual edge on pin 4
    wr(10'h010, 32'h0000_0010);
    padIn[4] = 1'b1;
    tick(3);
    rdReg(10'h01C, rd);
    chk("R6 dual rise", 64'(rd), 64'h10);
    wr(10'h024, 32'h10);
    padIn[4] = 1'b0;
    tick(3);
    rdReg(10'h01C, rd);
    chk("R6 dual fall", 64'(rd), 64'h10);
    wr(10'h024, 32'h10);

    // R4 level high on pin 5; clear while active does not stick
    wr(10'h014, 32'h0000_0028);
    wr(10'h00C, 32'h0000_0020);
    padIn[5] = 1'b1;
    tick(3);
    rdReg(10'h01C, rd);
    chk("R4 level high captured", 64'(rd), 64'h20);
    wr(10'h024, 32'h20);
    rdReg(10'h01C, rd);
    chk("R4 clear loses to active level", 64'(rd), 64'h20);
    padIn[5] = 1'b0;
    tick(3);
    wr(10'h024, 32'h20);
    rdReg(10'h01C, rd);
    chk("R4 clear after level gone", 64'(rd), 64'h0);

    // R4 level low on pin 6, R7 masking
    wr(10'h00C, 32'h0000_0060);
    tick(2);
    rdReg(10'h01C, rd);
    chk("R4 level low captured", 64'(rd), 64'h40);
    rdReg(10'h020, rd);
    chk("R7 masked status hides unmasked pin", 64'(rd), 64'h0);
    chk("R9 irq low when masked", 64'(irqOut), 64'h0);
    wr(10'h018, 32'h0000_0048);
    rdReg(10'h020, rd);
    chk("R7 masked status after unmask", 64'(rd), 64'h40);
    chk("R9 irq after unmask", 64'(irqOut), 64'h1);
    wr(10'h00C, 32'h0000_0020);
    wr(10'h024, 32'h40);
    chk("R9 irq clear bank0", 64'(irqOut), 64'h0);

    // R9 interrupt from bank 1 only (pin 40 level high)
    wr(10'h214, 32'h0000_0100);
    wr(10'h20C, 32'h0000_0100);
    wr(10'h218, 32'h0000_0100);
    tick(2);
    chk("R9 irq from bank1", 64'(irqOut), 64'h1);
    rdReg(10'h220, rd);
    chk("R7 bank1 masked status", 64'(rd), 64'h100);
    rdReg(10'h020, rd);
    chk("R1 bank0 masked status separate", 64'(rd), 64'h0);

    // R10 pulls, R11 drive code 6 (14 mA) on pin 5
    wr(10'h034, 32'h0000_0020);
    wr(10'h038, 32'h0000_0060);
    chk("R10 pullSel", 64'(pullSel), 64'h20);
    chk("R10 pullEn", 64'(pullEn), 64'h60);
    wr(10'h058, 32'h0);
    wr(10'h05C, 32'h0000_0020);
    wr(10'h060, 32'h0000_0020);
    chk("R11 drive code pin5", 64'(driveCode[17:15]), 64'h6);

    // R13 unmapped write leaves state alone
    wr(10'h03C, 32'hFFFF_FFFF);
    chk("R13 unmapped write no effect on pins", 64'(pullEn), 64'h60);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule